// File: doc/BRIEF.md
# Execution-Count Break Qualifier

This block decides, for a single debug-break channel, whether a match reported by upstream comparators should become a break request now or should instead be counted. Software loads a 12-bit countdown through a 16-bit register port. Each match strobe arrives with a two-bit instruction-class code. While the counting mode is on, each match lowers the count by a step of 1 to 4, taken from that code. Instructions that take several cycles therefore use up more of the budget for each match.

The break output is a one-cycle pulse in the same cycle as the match that qualifies. A match qualifies when the count already stands at one, or at zero, which is treated the same way. The count never wraps. A decrement that would fall below one stops at one, so every later match also breaks. With the counting mode off, every match breaks at once and the count is left alone. A register write in the same cycle as a match replaces the count. The break decision for that cycle still uses the count held before the write.

Top module: `exec_count_break`

## Requirements
- R1: After a synchronous reset the register reads 16'h0000 and no break is signalled.
- R2: A write stores bits 11..0 of the write data as the count. Bits 15..12 always read as zero, whatever was written. The largest count, 4095, is stored and read back unchanged.
- R3: With the counting mode off, a match raises the break output in the same cycle, and the count does not change.
- R4: With the counting mode on and the count greater than the step, a match raises no break and lowers the count by the step. Class code 0 gives a step of 1, code 1 a step of 2, code 2 a step of 3 and code 3 a step of 4.
- R5: With the counting mode on, a match while the count is 1 raises the break output in that cycle, and the count stays at 1.
- R6: With the counting mode on, a match whose step is equal to or larger than the count sets the count to 1. When the count was above 1 this raises no break.
- R7: With the counting mode on, a match at a count of 0 raises the break output, and the count becomes 1.
- R8: A write in the same cycle as a match loads the written value instead of the decremented one. The break output in that cycle depends on the count held before the write.
- R9: The break output is low in every cycle without a match strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the count register |
| reg_wr_data | input | 16 | Write data; only bits 11..0 are kept |
| reg_rd_data | output | 16 | Read value of the count register |
| cnt_mode_en | input | 1 | Enables the counting mode for the channel |
| match_vld | input | 1 | Match strobe from the channel's comparators |
| match_class | input | 2 | Instruction-class code of the match, which selects the step |
| brk_pulse | output | 1 | Break request, a one-cycle pulse |

## Verification
The bench aims at the ends of the count range. At a count of one, a design that decremented to zero or wrapped would stop breaking on the matches that follow. At a count of zero, a design that compared only against one would not break at all. It also checks steps larger than the remaining count, where a design without saturation would wrap to a count near 4095. Other checks cover writes that land on a match, where a design with the wrong priority would keep the decremented value. They also cover writes with the upper bits set, which would show up as non-zero reserved bits. Last, with the counting mode off, a design that still decremented would show a changed count.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  localparam int REG_W  = 16;
  localparam int CNT_W  = 12;
  localparam int CLS_W  = 2;
  localparam int STEP_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_PLAIN  = 2'd0,
    CLS_DOUBLE = 2'd1,
    CLS_RMW    = 2'd2,
    CLS_HEAVY  = 2'd3
  } match_class_e;
endpackage

// File: rtl/ecb_step_decode.sv
module ecb_step_decode
  import ecb_pkg::*;
#(
  parameter int STEP_WIDTH = STEP_W
) (
  input  logic [CLS_W-1:0]      cls_i,
  output logic [STEP_WIDTH-1:0] step_o
);
  match_class_e cls;
  assign cls = match_class_e'(cls_i);

  always_comb begin
    unique case (cls)
      CLS_PLAIN:  step_o = STEP_WIDTH'(1);
      CLS_DOUBLE: step_o = STEP_WIDTH'(2);
      CLS_RMW:    step_o = STEP_WIDTH'(3);
      CLS_HEAVY:  step_o = STEP_WIDTH'(4);
      default:    step_o = STEP_WIDTH'(1);
    endcase
  end
endmodule

// File: rtl/ecb_count_reg.sv
module ecb_count_reg #(
  parameter int CNT_WIDTH  = 12,
  parameter int STEP_WIDTH = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en_i,
  input  logic [CNT_WIDTH-1:0]  wr_cnt_i,
  input  logic                  dec_en_i,
  input  logic [STEP_WIDTH-1:0] step_i,
  output logic [CNT_WIDTH-1:0]  cnt_o
);
  localparam logic [CNT_WIDTH-1:0] ONE = CNT_WIDTH'(1);

  logic [CNT_WIDTH-1:0] cnt_q;
  logic [CNT_WIDTH-1:0] step_ext;
  logic [CNT_WIDTH-1:0] dec_val;

  assign step_ext = CNT_WIDTH'(step_i);
  // a step that reaches the count stops at one
  assign dec_val  = (cnt_q <= step_ext) ? ONE : (cnt_q - step_ext);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_en_i) begin
      cnt_q <= wr_cnt_i;
    end else if (dec_en_i) begin
      cnt_q <= dec_val;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ecb_break_qual.sv
module ecb_break_qual #(
  parameter int CNT_WIDTH = 12
) (
  input  logic                 mode_en_i,
  input  logic                 match_i,
  input  logic [CNT_WIDTH-1:0] cnt_i,
  output logic                 brk_o,
  output logic                 dec_en_o
);
  logic at_floor;
  // zero and one both count as the last allowed match
  assign at_floor = (cnt_i[CNT_WIDTH-1:1] == '0);
  assign brk_o    = match_i & (~mode_en_i | at_floor);
  assign dec_en_o = match_i & mode_en_i;
endmodule

// File: rtl/exec_count_break.sv
module exec_count_break
  import ecb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             cnt_mode_en,
  input  logic             match_vld,
  input  logic [CLS_W-1:0] match_class,
  output logic             brk_pulse
);
  localparam int PAD_W = REG_W - CNT_W;

  logic [STEP_W-1:0] step;
  logic [CNT_W-1:0]  cnt;
  logic              dec_en;
  logic              unused_hi_bits;

  assign unused_hi_bits = ^reg_wr_data[REG_W-1:CNT_W];

  ecb_step_decode #(.STEP_WIDTH(STEP_W)) u_step (
    .cls_i  (match_class),
    .step_o (step)
  );

  ecb_break_qual #(.CNT_WIDTH(CNT_W)) u_qual (
    .mode_en_i (cnt_mode_en),
    .match_i   (match_vld),
    .cnt_i     (cnt),
    .brk_o     (brk_pulse),
    .dec_en_o  (dec_en)
  );

  ecb_count_reg #(.CNT_WIDTH(CNT_W), .STEP_WIDTH(STEP_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (reg_wr_en),
    .wr_cnt_i (reg_wr_data[CNT_W-1:0]),
    .dec_en_i (dec_en),
    .step_i   (step),
    .cnt_o    (cnt)
  );

  assign reg_rd_data = {{PAD_W{1'b0}}, cnt};
endmodule

// File: rtl/ecb_checker.sv
module ecb_checker
  import ecb_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             reg_wr_en,
  input logic [REG_W-1:0] reg_wr_data,
  input logic [REG_W-1:0] reg_rd_data,
  input logic             cnt_mode_en,
  input logic             match_vld,
  input logic [CLS_W-1:0] match_class,
  input logic             brk_pulse
);
  logic [REG_W-1:0] step_w;
  assign step_w = REG_W'(match_class) + REG_W'(1);

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    reg_rd_data[REG_W-1:CNT_W] == '0);

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> reg_rd_data == {{(REG_W-CNT_W){1'b0}}, $past(reg_wr_data[CNT_W-1:0])});

  assert_off_breaks_R3: assert property (@(posedge clk) disable iff (rst)
    (match_vld && !cnt_mode_en) |-> brk_pulse);

  assert_off_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (match_vld && !cnt_mode_en && !reg_wr_en) |=> $stable(reg_rd_data));

  assert_no_match_no_break_R9: assert property (@(posedge clk) disable iff (rst)
    !match_vld |-> !brk_pulse);

  assert_last_breaks_R5: assert property (@(posedge clk) disable iff (rst)
    (match_vld && cnt_mode_en && reg_rd_data <= 16'd1) |-> brk_pulse);

  assert_floor_one_R6: assert property (@(posedge clk) disable iff (rst)
    (match_vld && cnt_mode_en && !reg_wr_en && reg_rd_data <= step_w) |=> reg_rd_data == 16'd1);

  assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
    (match_vld && cnt_mode_en && !reg_wr_en && reg_rd_data > step_w)
      |-> !brk_pulse ##1 (reg_rd_data == $past(reg_rd_data) - $past(step_w)));
endmodule

bind exec_count_break ecb_checker u_ecb_checker (
  .clk         (clk),
  .rst         (rst),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .reg_rd_data (reg_rd_data),
  .cnt_mode_en (cnt_mode_en),
  .match_vld   (match_vld),
  .match_class (match_class),
  .brk_pulse   (brk_pulse)
);

// File: tb/exec_count_break_tb_top.sv
module exec_count_break_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [15:0] reg_wr_data = '0;
  logic [15:0] reg_rd_data;
  logic        cnt_mode_en = 1'b0;
  logic        match_vld = 1'b0;
  logic [1:0]  match_class = '0;
  logic        brk_pulse;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic        brk;
    logic [15:0] rd;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  logic [11:0] cnt_m = '0;

  always #2.5 clk = ~clk;

  exec_count_break dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .cnt_mode_en(cnt_mode_en), .match_vld(match_vld),
    .match_class(match_class), .brk_pulse(brk_pulse)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the model's prediction
  task automatic op(input string tag, input logic wr, input logic [15:0] wd,
                    input logic mode, input logic mv, input logic [1:0] cls);
    exp_t e;
    logic [11:0] step;
    @(negedge clk);
    reg_wr_en = wr; reg_wr_data = wd; cnt_mode_en = mode;
    match_vld = mv; match_class = cls;
    e.brk = mv && (!mode || cnt_m <= 12'd1);
    step = 12'(cls) + 12'd1;
    if (wr) cnt_m = wd[11:0];
    else if (mv && mode) cnt_m = (cnt_m <= step) ? 12'd1 : cnt_m - step;
    e.rd  = {4'b0, cnt_m};
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: break sampled before the edge, count after it
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " brk"}, {15'b0, brk_pulse}, {15'b0, e.brk});
        @(posedge clk);
        #1;
        check({e.tag, " count"}, reg_rd_data, e.rd);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 reset read", reg_rd_data, 16'h0000);
    check("R1 reset brk", {15'b0, brk_pulse}, 16'h0000);

    op("R2 write rsvd", 1, 16'hFABC, 0, 0, 0);
    op("R2 write max",  1, 16'h0FFF, 0, 0, 0);
    op("R9 idle",       0, 16'h0000, 1, 0, 0);
    op("R3 mode off",   0, 16'h0000, 0, 1, 3);
    op("R3 mode off 2", 0, 16'h0000, 0, 1, 0);

    op("R4 load", 1, 16'd100, 1, 0, 0);
    for (int c = 0; c < 4; c++) op("R4 step", 0, 16'h0, 1, 1, 2'(c));

    op("R6 load",     1, 16'd3, 1, 0, 0);
    op("R6 saturate", 0, 16'h0, 1, 1, 3);
    op("R5 at one",   0, 16'h0, 1, 1, 0);
    op("R5 again",    0, 16'h0, 1, 1, 2);
    op("R9 idle one", 0, 16'h0, 1, 0, 0);

    op("R6 equal load", 1, 16'd4, 1, 0, 0);
    op("R6 equal step", 0, 16'h0, 1, 1, 3);

    op("R7 load zero", 1, 16'd0, 1, 0, 0);
    op("R7 at zero",   0, 16'h0, 1, 1, 1);

    op("R8 wr at one",  1, 16'd50, 1, 1, 0);
    op("R8 wr at 50",   1, 16'hF007, 1, 1, 3);
    op("R8 after",      0, 16'h0, 1, 1, 0);

    op("R9 final", 0, 16'h0, 0, 0, 0);
    @(negedge clk);
    reg_wr_en = 0; match_vld = 0;
    wait (sb_q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule